// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks a multi-register load or store. A caller hands it a base address, a register mask of `NREG` bits, an addressing mode, a load/store flag and a writeback flag. The block then presents one word address and one register number per transfer on a valid/ready request port. When the last transfer has been accepted, it pulses `done` and shows the updated base value.

The block handles the four direct modes. It also handles the four stack-style aliases, and it resolves each alias according to the transfer direction. Registers always go out in ascending index order, and addresses always climb by 4. A decrementing mode therefore starts below the base, so the lowest-numbered register still lands at the lowest address. The memory bus and the register file sit outside this block.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `start_ready` is 1, and `req_valid` and `done` are 0.
- R2: A command is accepted only on a cycle where `start_valid` and `start_ready` are both 1. `start_ready` is 0 while transfers are outstanding. A `start_valid` held high during a transfer changes neither that transfer's addresses nor its register numbers. It also does not start another transfer if it is dropped in the `done` cycle.
- R3: The `start_mode` codes 0 to 3 are direct modes. Code 0 is increment-after and gives a first address of base. Code 1 is increment-before and gives base+4. Code 2 is decrement-after and gives base-4n+4. Code 3 is decrement-before and gives base-4n. Here n is the number of set mask bits, and all arithmetic wraps modulo 2^AW.
- R4: When `start_load`=1, the alias codes resolve as follows. Code 4 (full-descending) acts as code 0. Code 5 (empty-descending) acts as code 1. Code 6 (full-ascending) acts as code 2. Code 7 (empty-ascending) acts as code 3.
- R5: When `start_load`=0, the alias codes resolve as follows. Code 7 (empty-ascending) acts as code 0. Code 6 (full-ascending) acts as code 1. Code 5 (empty-descending) acts as code 2. Code 4 (full-descending) acts as code 3.
- R6: One transfer is issued per set mask bit, in ascending register index. Each transfer's address is 4 above the previous one.
- R7: While `req_valid`=1 and `req_ready`=0, `req_addr` and `req_idx` hold steady.
- R8: `done` is high for exactly the one cycle that follows acceptance of the last transfer. `req_valid` is 0 in that cycle.
- R9: In the `done` cycle, `wb_base` is base+4n for an increment mode and base-4n for a decrement mode. `wb_en` equals the command's writeback flag.
- R10: An empty mask produces no transfers. It raises `done` in the cycle after acceptance, with `wb_base` equal to base and `wb_en` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Command offered |
| start_ready | output | 1 | Sequencer idle, command can be taken |
| start_load | input | 1 | 1 = load (pop), 0 = store (push) |
| start_mode | input | 3 | Addressing mode code (R3 to R5) |
| start_wback | input | 1 | Request base update at end |
| start_base | input | AW | Base address |
| start_list | input | NREG | Register mask |
| req_valid | output | 1 | Transfer request present |
| req_ready | input | 1 | Transfer request accepted |
| req_addr | output | AW | Word address of this transfer |
| req_idx | output | IW | Register number of this transfer |
| done | output | 1 | One-cycle end-of-command pulse |
| wb_en | output | 1 | Base update wanted (valid with done) |
| wb_base | output | AW | Updated base value (valid with done) |

## Verification
A corrupted remaining-mask register shows up directly at the ports. The next `req_idx` comes out skipped or repeated, and the transfer count and the `done` cycle shift. A bad address register shows as a wrong `req_addr` on the very next request. Mode decode errors are visible on the first request, and writeback errors in the `done` cycle. The bench sweeps all eight mode codes against both directions and several masks and bases, with stalls mixed in, so each such fault surfaces within one command.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic          start_load,
  input  logic [2:0]    start_mode,
  input  logic          start_wback,
  input  logic [AW-1:0] start_base,
  input  logic [NREG-1:0] start_list,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [IW-1:0] req_idx,
  output logic          done,
  output logic          wb_en,
  output logic [AW-1:0] wb_base
);

  localparam logic [AW-1:0] WORD = AW'(4);

  function automatic logic [CW-1:0] popc(input logic [NREG-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  function automatic logic [IW-1:0] lowest(input logic [NREG-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NREG - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  logic [NREG-1:0] list_q;
  logic [AW-1:0]   addr_q, wbv_q;
  logic            busy_q, done_q, wbe_q;

  // bit1: decrement, bit0: before
  logic [1:0] bmode;
  assign bmode = !start_mode[2] ? start_mode[1:0] :
                 start_load     ? start_mode[1:0] : ~start_mode[1:0];

  logic [AW-1:0] span, first_addr;
  logic          nonempty, fire, step, last;
  assign span     = AW'(popc(start_list)) << 2;
  assign nonempty = |start_list;
  assign fire     = start_valid && !busy_q;
  assign step     = busy_q && req_ready;
  assign last     = (list_q & (list_q - 1'b1)) == '0;

  always_comb begin
    case (bmode)
      2'd0:    first_addr = start_base;
      2'd1:    first_addr = start_base + WORD;
      2'd2:    first_addr = start_base - span + WORD;
      default: first_addr = start_base - span;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      list_q <= '0;
      addr_q <= '0;
      wbv_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wbe_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        list_q <= start_list;
        addr_q <= first_addr;
        busy_q <= nonempty;
        done_q <= !nonempty;
        wbe_q  <= start_wback && nonempty;
        wbv_q  <= !nonempty ? start_base :
                  bmode[1]  ? start_base - span : start_base + span;
      end else if (step) begin
        list_q <= list_q & (list_q - 1'b1);
        addr_q <= addr_q + WORD;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign start_ready = !busy_q;
  assign req_valid   = busy_q;
  assign req_addr    = addr_q;
  assign req_idx     = lowest(list_q);
  assign done        = done_q;
  assign wb_en       = done_q && wbe_q;
  assign wb_base     = wbv_q;

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid || req_addr == $past(req_addr) + WORD));

  a_r6_idx_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid || req_idx > $past(req_idx)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_idx)));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req_valid && start_ready));

  a_r10_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && start_list == '0) |=> (done && !req_valid && !wb_en));

endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;
  localparam int AW = 32, NREG = 16, IW = 4;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, start_load = 0, start_wback = 0, req_ready = 0;
  logic [2:0] start_mode = 0;
  logic [AW-1:0] start_base = 0;
  logic [NREG-1:0] start_list = 0;
  logic start_ready, req_valid, done, wb_en;
  logic [AW-1:0] req_addr, wb_base;
  logic [IW-1:0] req_idx;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  blk_xfer_seq #(.AW(AW), .NREG(NREG)) i_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_load(start_load), .start_mode(start_mode), .start_wback(start_wback),
    .start_base(start_base), .start_list(start_list), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_idx(req_idx), .done(done),
    .wb_en(wb_en), .wb_base(wb_base));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Resolve mode code to direct mode 0..3 per R3/R4/R5
  function automatic int resolve(input int code, input bit load);
    if (code < 4) return code;
    if (load) begin
      case (code) 4: return 0; 5: return 1; 6: return 2; default: return 3; endcase
    end else begin
      case (code) 7: return 0; 6: return 1; 5: return 2; default: return 3; endcase
    end
  endfunction

  task automatic run(input logic [31:0] base, input logic [15:0] list, input int code,
                     input bit load, input bit wb, input bit junk);
    int n, dm, k;
    logic [31:0] a0, ewb;
    n = $countones(list);
    dm = resolve(code, load);
    case (dm)
      0: a0 = base;
      1: a0 = base + 4;
      2: a0 = base - 32'(4 * n) + 4;
      default: a0 = base - 32'(4 * n);
    endcase
    ewb = (n == 0) ? base : (dm >= 2 ? base - 32'(4 * n) : base + 32'(4 * n));
    @(negedge clk);
    check(start_ready == 1, "R2 ready idle", start_ready, 1);
    start_valid = 1; start_base = base; start_list = list; start_mode = 3'(code);
    start_load = load; start_wback = wb; req_ready = 0;
    @(negedge clk);
    if (junk) begin
      start_list = ~list; start_base = base ^ 32'h55; start_mode = 3'(code ^ 3);
    end else start_valid = 0;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        if (((k + code) % 3) == 0) begin
          req_ready = 0;
          check(req_valid == 1, "R7 valid", req_valid, 1);
          @(negedge clk);
          check(req_valid == 1, "R7 valid held", req_valid, 1);
          check(req_addr == a0 + 32'(4 * k), "R7 addr held", req_addr, a0 + 32'(4 * k));
          check(req_idx == IW'(i), "R7 idx held", req_idx, i);
        end
        req_ready = 1;
        check(req_valid == 1, "R6 valid", req_valid, 1);
        check(start_ready == 0, "R2 busy", start_ready, 0);
        if (k == 0)
          check(req_addr == a0, (code < 4) ? "R3 first addr" : (load ? "R4 first addr" : "R5 first addr"), req_addr, a0);
        else
          check(req_addr == a0 + 32'(4 * k), junk ? "R2 addr under junk" : "R6 addr", req_addr, a0 + 32'(4 * k));
        check(req_idx == IW'(i), "R6 idx", req_idx, i);
        k++;
        @(negedge clk);
      end
    end
    req_ready = 0;
    start_valid = 0;
    check(done == 1, n == 0 ? "R10 done" : "R8 done", done, 1);
    check(req_valid == 0, "R8 idle at done", req_valid, 0);
    check(wb_base == ewb, n == 0 ? "R10 wb_base" : "R9 wb_base", wb_base, ewb);
    check(wb_en == (wb && n != 0), n == 0 ? "R10 wb_en" : "R9 wb_en", wb_en, (wb && n != 0));
    @(negedge clk);
    check(done == 0, "R8 done pulse", done, 0);
    check(req_valid == 0, "R2 no extra start", req_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lists [6];
    logic [31:0] bases [2];
    lists[0] = 16'h0001; lists[1] = 16'h8000; lists[2] = 16'hFFFF;
    lists[3] = 16'h0000; lists[4] = 16'hA5C3; lists[5] = 16'h0110;
    bases[0] = 32'h0000_1000; bases[1] = 32'h0000_0008;
    #1;
    check(start_ready == 1, "R1 ready", start_ready, 1);
    check(req_valid == 0, "R1 req_valid", req_valid, 0);
    check(done == 0, "R1 done", done, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    check(start_ready == 1 && req_valid == 0 && done == 0, "R1 after release", {start_ready, req_valid, done}, 3'b100);
    for (int b = 0; b < 2; b++)
      for (int l = 0; l < 6; l++)
        for (int m = 0; m < 8; m++)
          for (int ld = 0; ld < 2; ld++)
            run(bases[b], lists[l], m, ld[0], m[0] ^ l[0], 1'b0);
    for (int l = 0; l < 6; l++)
      run(32'h0000_2000, lists[l], l, l[0], 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule